// File: doc/BRIEF.md
# Wide-to-Narrow Register Bus Bridge

This block connects a 64-bit register bus master to a slave that has only an 8-bit data path and a 12-bit address. The master marks the byte it wants with a one-hot byte-select mask. The bridge turns the position of that select bit into the slave's three lowest address bits. It routes the matching write byte down to the slave and returns the slave's read byte on the same lane of the wide read bus.

Accesses that select no byte, or more than one, cannot be expressed as a single narrow access. The slave never sees them. The master receives a one-cycle error pulse instead. The bridge adds no pipeline stage: the slave's acknowledge and read data reach the master combinationally in the same cycle.

Top module: `wide_narrow_bridge`

## Requirements
- R1: `s_adr[11:3]` equals `m_adr[11:3]`. For a request with exactly one select bit set, `s_adr[2:0]` is the index of that bit, where `m_sel[0]` is the least significant byte (lane 0 = `m_dat_w[7:0]`).
- R2: For a single-lane request at lane k, `s_dat_w` equals `m_dat_w[8k+7:8k]`.
- R3: For a single-lane request at lane k, `m_dat_r[8k+7:8k]` equals `s_dat_r` and every other lane is zero. For any other select mask, `m_dat_r` is all zero.
- R4: When `m_sel` has zero bits or two or more bits set, `s_cyc` and `s_stb` stay low.
- R5: Out of reset, for a single-lane request, `s_cyc` follows `m_cyc` and `s_stb` follows `m_stb`. `s_we` always follows `m_we`.
- R6: `m_ack` equals `s_ack` AND `m_cyc` AND `m_stb` AND (exactly one select bit set), in the same cycle.
- R7: A rejected request (R4 mask, with `m_cyc` and `m_stb` high) seen at a clock edge while `m_err` is low raises `m_err` in the following cycle, provided the rejected request is still present then. `m_err` is never high in two consecutive cycles and never together with `m_ack`.
- R8: While `rst_n` is low (synchronous, active low), `s_cyc` and `s_stb` are low, and `m_err` is low in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_adr | input | 32 | Master byte address |
| m_dat_w | input | 64 | Master write data |
| m_sel | input | 8 | Master byte-lane select mask |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_dat_r | output | 64 | Read data back to master |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Error response to master |
| s_adr | output | 12 | Slave address |
| s_dat_w | output | 8 | Slave write data |
| s_dat_r | input | 8 | Slave read data |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_ack | input | 1 | Slave acknowledge |

## Verification
The only internal state is the error-pulse flag. If it is stuck, or clears at the wrong time, the fault appears on `m_err` one cycle after a rejected request: the pulse is missing, doubled, or present during reset. All other paths are combinational. A wrong lane decode therefore shows in the same cycle as a misplaced byte on `s_dat_w` or `m_dat_r`, or as wrong low bits on `s_adr`. A reference model compares every output on every clock under directed lane sweeps and random masks.

// File: rtl/wnb_pkg.sv
// Shared types for the wide-to-narrow bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package wnb_pkg;
    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_SENT = 1'b1
    } err_state_e;
endpackage

// File: rtl/wnb_lane_decode.sv
// Lane decoder: reports whether exactly one select bit is set and,
// if so, its index.
// Assumes: the index output is meaningful only when single_o is high.
module wnb_lane_decode #(
    parameter int LANES = 8,
    localparam int LB = $clog2(LANES)
) (
    input  logic [LANES-1:0] sel_i,
    output logic [LB-1:0]    idx_o,
    output logic             single_o
);
    localparam int CW = $clog2(LANES + 1);

    // Purpose: count the set bits and record the position of a set bit.
    always_comb begin
        logic [CW-1:0] cnt;
        cnt   = '0;
        idx_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel_i[i]) begin
                cnt   = cnt + CW'(1);
                idx_o = LB'(i);
            end
        end
        single_o = (cnt == CW'(1));
    end

    // Purpose: a single-lane result must point at a selected lane.
    always_comb begin
        if (single_o) assert_idx_hits_sel_R1: assert (sel_i[idx_o]);
    end
endmodule

// File: rtl/wnb_lane_steer.sv
// Data steering: selects the write byte for the slave and places the
// slave's read byte onto the chosen lane of the wide read bus.
// Assumes: valid_i is high only for a single-lane request.
module wnb_lane_steer #(
    parameter int LANES = 8,
    parameter int SW    = 8,
    localparam int LB   = $clog2(LANES),
    localparam int MW   = LANES * SW
) (
    input  logic [LB-1:0] idx_i,
    input  logic          valid_i,
    input  logic [MW-1:0] wide_w_i,
    output logic [SW-1:0] narrow_w_o,
    input  logic [SW-1:0] narrow_r_i,
    output logic [MW-1:0] wide_r_o
);
    logic [LANES-1:0] lane_en;

    // Purpose: pick the write byte of the active lane.
    always_comb narrow_w_o = wide_w_i[idx_i*SW +: SW];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: drive one read lane, zero unless it is the active lane.
        assign lane_en[g] = valid_i && (idx_i == LB'(g));
        assign wide_r_o[g*SW +: SW] = lane_en[g] ? narrow_r_i : '0;
    end

    // Purpose: at most one read lane may carry data.
    always_comb begin
        assert_one_lane_R3: assert ($onehot0(lane_en));
    end
endmodule

// File: rtl/wnb_err_resp.sv
// Error responder: answers a rejected request with a single-cycle
// error pulse one clock after it is first seen.
// Assumes: synchronous active-low reset.
module wnb_err_resp
    import wnb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_req_i,
    output logic err_o
);
    err_state_e state_q;

    // Purpose: arm the pulse on a new rejected request, then drop it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ERR_IDLE;
        else if (bad_req_i && state_q == ERR_IDLE)
            state_q <= ERR_SENT;
        else
            state_q <= ERR_IDLE;
    end

    assign err_o = (state_q == ERR_SENT) && bad_req_i;

    // Purpose: the error response lasts at most one cycle.
    assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
endmodule

// File: rtl/wide_narrow_bridge.sv
// Bridge from a 64-bit byte-selected register bus to an 8-bit slave.
// Derives the slave's low address bits from the one-hot byte select,
// steers data on the matching lane, and rejects multi-lane or empty
// selects with an error pulse. Adds no latency on the ack/data path.
// Assumes: classic (non-pipelined) single accesses, synchronous
// active-low reset.
module wide_narrow_bridge #(
    parameter int MAW = 32,
    parameter int MDW = 64,
    parameter int SDW = 8,
    parameter int SAW = 12,
    localparam int LANES = MDW / SDW,
    localparam int LB    = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAW-1:0]   m_adr,
    input  logic [MDW-1:0]   m_dat_w,
    input  logic [LANES-1:0] m_sel,
    input  logic             m_cyc,
    input  logic             m_stb,
    input  logic             m_we,
    output logic [MDW-1:0]   m_dat_r,
    output logic             m_ack,
    output logic             m_err,
    output logic [SAW-1:0]   s_adr,
    output logic [SDW-1:0]   s_dat_w,
    input  logic [SDW-1:0]   s_dat_r,
    output logic             s_cyc,
    output logic             s_stb,
    output logic             s_we,
    input  logic             s_ack
);
    logic [LB-1:0] lane_idx;
    logic          lane_single;
    logic          bad_req;

    wnb_lane_decode #(.LANES(LANES)) u_dec (
        .sel_i    (m_sel),
        .idx_o    (lane_idx),
        .single_o (lane_single)
    );

    wnb_lane_steer #(.LANES(LANES), .SW(SDW)) u_steer (
        .idx_i      (lane_idx),
        .valid_i    (lane_single),
        .wide_w_i   (m_dat_w),
        .narrow_w_o (s_dat_w),
        .narrow_r_i (s_dat_r),
        .wide_r_o   (m_dat_r)
    );

    // Purpose: flag a live request that cannot map to one narrow access.
    assign bad_req = m_cyc && m_stb && !lane_single;

    wnb_err_resp u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_req_i (bad_req),
        .err_o     (m_err)
    );

    // Purpose: forward control to the slave, gated by reset and lane check.
    assign s_cyc = rst_n && lane_single && m_cyc;
    assign s_stb = rst_n && lane_single && m_stb;
    assign s_we  = m_we;

    // Purpose: keep upper word address, replace low bits by lane index.
    assign s_adr = {m_adr[SAW-1:LB], lane_idx};

    // Purpose: return the slave ack only for a live, accepted request.
    assign m_ack = s_ack && m_cyc && m_stb && lane_single;

    // Purpose: a rejected select mask never reaches the slave.
    assert_reject_blocks_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(m_sel) != 1) |-> (!s_cyc && !s_stb));

    // Purpose: ack and error are mutually exclusive.
    assert_ack_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_ack && m_err));

    // Purpose: a forwarded cycle carries a low address bit set that hits a selected lane.
    assert_addr_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_cyc |-> m_sel[s_adr[LB-1:0]]);

    // Purpose: slave stays idle while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) assert_reset_quiet_R8: assert (!s_cyc && !s_stb);
    end
endmodule

// File: tb/wide_narrow_bridge_tb_top.sv
module wide_narrow_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] m_adr = '0;
    logic [63:0] m_dat_w = '0;
    logic [7:0]  m_sel = '0;
    logic        m_cyc = 1'b0, m_stb = 1'b0, m_we = 1'b0;
    logic [63:0] m_dat_r;
    logic        m_ack, m_err;
    logic [11:0] s_adr;
    logic [7:0]  s_dat_w;
    logic [7:0]  s_dat_r = '0;
    logic        s_cyc, s_stb, s_we;
    logic        s_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit model_errq = 1'b0;
    int cycles = 0;

    always #2 clk = ~clk;

    wide_narrow_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .m_adr(m_adr), .m_dat_w(m_dat_w),
        .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
        .m_dat_r(m_dat_r), .m_ack(m_ack), .m_err(m_err),
        .s_adr(s_adr), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_ack(s_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model: error flag advances at each edge.
    always @(posedge clk) begin
        int n;
        cycles++;
        n = $countones(m_sel);
        if (!rst_n) model_errq = 1'b0;
        else        model_errq = m_cyc && m_stb && (n != 1) && !model_errq;
    end

    // Compare every output in mid-cycle.
    always @(negedge clk) begin
        if (running) begin
            int n, k;
            bit good;
            logic [63:0] er;
            n = $countones(m_sel);
            good = (n == 1);
            k = 0;
            for (int i = 0; i < 8; i++) if (m_sel[i]) k = i;
            er = good ? (64'(s_dat_r) << (8 * k)) : 64'd0;
            chk("R1 s_adr[11:3]", 64'(s_adr[11:3]), 64'(m_adr[11:3]));
            if (good) begin
                chk("R1 s_adr[2:0]", 64'(s_adr[2:0]), 64'(k));
                chk("R2 s_dat_w", 64'(s_dat_w), 64'(m_dat_w[8*k +: 8]));
            end
            chk("R3 m_dat_r", m_dat_r, er);
            if (!good) chk("R4 s_cyc/s_stb", 64'({s_cyc, s_stb}), 64'd0);
            if (!rst_n) chk("R8 s_cyc/s_stb in reset", 64'({s_cyc, s_stb}), 64'd0);
            if (rst_n && good) chk("R5 s_cyc/s_stb", 64'({s_cyc, s_stb}), 64'({m_cyc, m_stb}));
            chk("R5 s_we", 64'(s_we), 64'(m_we));
            chk("R6 m_ack", 64'(m_ack), 64'(s_ack && m_cyc && m_stb && good));
            chk("R7 m_err", 64'(m_err), 64'(model_errq && m_cyc && m_stb && !good));
        end
    end

    task automatic drive(input logic [7:0] sel, input bit cyc, input bit stb,
                         input bit we, input bit ack);
        @(posedge clk);
        #1;
        m_sel   = sel;
        m_cyc   = cyc;
        m_stb   = stb;
        m_we    = we;
        s_ack   = ack;
        m_adr   = $urandom;
        m_dat_w = {$urandom, $urandom};
        s_dat_r = 8'($urandom);
    endtask

    initial begin
        running = 1'b1;
        // R8: live single-lane request during reset must not reach the slave.
        drive(8'h04, 1, 1, 1, 0);
        drive(8'h10, 1, 1, 0, 1);
        drive(8'h03, 1, 1, 0, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1 R2 R3 R6: sweep every lane for writes and reads.
        for (int l = 0; l < 8; l++) begin
            drive(8'(1 << l), 1, 1, 1, 1);
            drive(8'(1 << l), 1, 1, 0, 1);
        end
        // R4 R7: zero mask held for several cycles (pulse, gap, pulse).
        for (int j = 0; j < 5; j++) drive(8'h00, 1, 1, 0, 0);
        // R7: multi-lane with slave ack high must still not ack.
        for (int j = 0; j < 3; j++) drive(8'hFF, 1, 1, 1, 1);
        // R7: rejected request withdrawn before the pulse.
        drive(8'h81, 1, 1, 0, 0);
        drive(8'h00, 0, 0, 0, 0);
        drive(8'h81, 1, 0, 0, 0);
        // R5 R6: strobe low, cycle high.
        drive(8'h20, 1, 0, 1, 1);
        // R8: reset in the middle of a rejected request.
        drive(8'h06, 1, 1, 0, 0);
        @(posedge clk); #1 rst_n = 1'b0;
        drive(8'h06, 1, 1, 0, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        // Random traffic.
        for (int j = 0; j < 400; j++) begin
            logic [7:0] s;
            s = ($urandom % 3 != 0) ? 8'(1 << ($urandom % 8)) : 8'($urandom);
            drive(s, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        drive(8'h00, 0, 0, 0, 0);
        @(posedge clk);
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule